// File: doc/BRIEF.md
# Asynchronous Host Memory Bus Slave

This block is the slave end of an asynchronous strobe-and-acknowledge host port. A processor uses it to reach a local memory built from 16-bit words, and a small register file beside that memory. The host holds an active-low select low to start an access. It drives the address, the read/write direction and, for writes, the data. The block brings select, direction and the two word-lane enables into its own clock domain through a two-flop synchroniser. It captures the command, performs the access and then pulls an active-low ready output. On a read, ready means the data is being driven. On a write, ready means the data has been taken. Ready stays low until the host lets go of select.

In 32-bit mode, each access covers a pair of 16-bit words: the even word sits on bits 15..0 and the odd word on bits 31..16. Each half has its own lane enable. A half whose lane is off is not written, and it reads back as zero. In 16-bit mode, each access covers one word on bits 15..0, and the lane enables have no effect. The top address bit selects the register file. A 32-bit register access needs both lanes on. If it does not have them, the access is still acknowledged, so the bus cannot hang, but it changes nothing and reads as zero. The read data goes out on a separate output with an output-enable, which drives the external tri-state pad.

Top module: `host_async_slave`

## Requirements
- R1: In 32-bit mode (mode32_i=1) the row is addr_i[MEM_AW:1] and addr_i[0] is ignored. The lower lane enable lane_en_i[0] qualifies data bits 15..0, which map to memory word 2*row. The upper lane enable lane_en_i[1] qualifies data bits 31..16, which map to word 2*row+1.
- R2: On a 32-bit memory write, a half whose lane enable is 0 keeps its stored value. A half whose lane enable is 1 is written.
- R3: On a 32-bit memory read, a half whose lane enable is 0 reads as 0x0000. A half whose lane enable is 1 reads the stored word.
- R4: In 16-bit mode (mode32_i=0) the word address is addr_i[MEM_AW:0]. Only data_i[15:0] is written, and lane_en_i is ignored.
- R5: addr_i[ADDR_W-1]=1 selects the register file, with the row taken from addr_i[REG_AW:1]. In 32-bit mode, a register access with lane_en_i other than 2'b11 leaves the registers unchanged and reads 0x00000000, but is still acknowledged. In 16-bit mode, register accesses always proceed.
- R6: After select falls, rdy_no goes low on the 5th rising clock edge. By then the read data is on data_o, or the write data has been captured.
- R7: Once low, rdy_no stays low while select is held low. It returns high on the 3rd rising edge after select rises, and no new access starts before that.
- R8: In 16-bit mode, read data drives data_o[31:16] as zero.
- R9: data_oe_o is high only while ready is asserted for a read. During reset, rdy_no=1 and data_oe_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_ni | input | 1 | Active-low access select (asynchronous) |
| rd_wr_i | input | 1 | 1 = read, 0 = write (asynchronous) |
| mode32_i | input | 1 | 1 = 32-bit mode, 0 = 16-bit mode (static) |
| lane_en_i | input | 2 | Word-lane enables, bit 1 = upper half, bit 0 = lower half |
| addr_i | input | ADDR_W | {register select, row, half} |
| data_i | input | 32 | Write data from host |
| data_o | output | 32 | Read data to host pad |
| data_oe_o | output | 1 | Pad output enable |
| rdy_no | output | 1 | Active-low ready / acknowledge |

## Verification
Two synchroniser flops, the idle-to-access step, the access step and the data-latch step sit between select falling and ready asserting. Ready is therefore due on the fifth rising edge, and the bench counts edges until it sees ready and compares that count with five. Ready should come back high on the third edge after release, and the bench checks that count the same way. The bench drives inputs on falling edges, reads data_o and data_oe_o one step after the edge where ready is first seen, and checks them against a word-level model of memory and registers. It sweeps every memory word in both modes, every lane pattern and every register row.

// File: rtl/host_async_pkg.sv
package host_async_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_ACK    = 2'd2,
    ST_WAIT   = 2'd3
  } hst_state_e;

  localparam int unsigned LANE_W = 16;
  localparam int unsigned NLANES = 2;
endpackage

// File: rtl/host_async_sync.sv
module host_async_sync #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/host_async_fsm.sv
module host_async_fsm
  import host_async_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_s_i,   // synchronised, active low
  output hst_state_e state_o,
  output logic       capture_o,
  output logic       access_o,
  output logic       latch_o,
  output logic       hold_o
);
  hst_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (!sel_s_i) state_d = ST_ACCESS;
      ST_ACCESS: state_d = ST_ACK;
      ST_ACK:    state_d = ST_WAIT;
      ST_WAIT:   if (sel_s_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign capture_o = (state_q == ST_IDLE) && !sel_s_i;
  assign access_o  = (state_q == ST_ACCESS);
  assign latch_o   = (state_q == ST_ACK);
  assign hold_o    = (state_q == ST_WAIT);
endmodule

// File: rtl/host_async_bank.sv
module host_async_bank #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 16,
  localparam int unsigned DEPTH = 2 ** AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/host_async_slave.sv
module host_async_slave
  import host_async_pkg::*;
#(
  parameter int unsigned MEM_AW = 6,
  parameter int unsigned REG_AW = 2,
  localparam int unsigned ADDR_W = MEM_AW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              rd_wr_i,
  input  logic              mode32_i,
  input  logic [1:0]        lane_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       data_i,
  output logic [31:0]       data_o,
  output logic              data_oe_o,
  output logic              rdy_no
);
  localparam int unsigned REG_BIT = ADDR_W - 1;

  // synchronised control: {lane[1:0], rd_wr, sel_n}
  logic [3:0] ctl_s;
  logic       sel_s, rd_s;
  logic [1:0] lane_s;

  host_async_sync #(.W(4), .RST_VAL(4'b0001)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({lane_en_i, rd_wr_i, sel_ni}),
    .q_o    (ctl_s)
  );
  assign sel_s  = ctl_s[0];
  assign rd_s   = ctl_s[1];
  assign lane_s = ctl_s[3:2];

  hst_state_e state;
  logic capture, access, latch, hold;

  host_async_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_s_i   (sel_s),
    .state_o   (state),
    .capture_o (capture),
    .access_o  (access),
    .latch_o   (latch),
    .hold_o    (hold)
  );

  // captured command
  logic              cmd_rd, cmd_m32;
  logic [1:0]        cmd_lane;
  logic [ADDR_W-1:0] cmd_addr;
  logic [31:0]       cmd_wd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_rd   <= 1'b0;
      cmd_m32  <= 1'b0;
      cmd_lane <= 2'b11;
      cmd_addr <= '0;
      cmd_wd   <= '0;
    end else if (capture) begin
      cmd_rd   <= rd_s;
      cmd_m32  <= mode32_i;
      cmd_lane <= mode32_i ? lane_s : 2'b11;  // 16-bit mode: lanes forced on
      cmd_addr <= addr_i;
      cmd_wd   <= data_i;
    end
  end

  logic is_reg, allow;
  assign is_reg = cmd_addr[REG_BIT];
  assign allow  = !is_reg || (cmd_lane == 2'b11);

  logic [1:0]        lane_act, mem_we, reg_we;
  logic [LANE_W-1:0] rd_lane [NLANES];

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    logic [LANE_W-1:0] wd, mem_q, reg_q, src_q;

    assign lane_act[i] = cmd_m32 ? cmd_lane[i] : (cmd_addr[0] == 1'(i));
    assign wd          = cmd_m32 ? cmd_wd[LANE_W*i +: LANE_W] : cmd_wd[LANE_W-1:0];
    assign mem_we[i]   = access && !cmd_rd && !is_reg && lane_act[i];
    assign reg_we[i]   = access && !cmd_rd && is_reg && allow && lane_act[i];

    host_async_bank #(.AW(MEM_AW), .DW(LANE_W)) u_mem (
      .clk_i   (clk_i),
      .we_i    (mem_we[i]),
      .addr_i  (cmd_addr[MEM_AW:1]),
      .wdata_i (wd),
      .rdata_o (mem_q)
    );

    host_async_bank #(.AW(REG_AW), .DW(LANE_W)) u_reg (
      .clk_i   (clk_i),
      .we_i    (reg_we[i]),
      .addr_i  (cmd_addr[REG_AW:1]),
      .wdata_i (wd),
      .rdata_o (reg_q)
    );

    assign src_q      = is_reg ? reg_q : mem_q;
    assign rd_lane[i] = (lane_act[i] && allow) ? src_q : '0;
  end

  logic [31:0] dout_d, dout_q;
  // 16-bit mode: only one lane is active, fold it onto the low half
  assign dout_d = cmd_m32 ? {rd_lane[1], rd_lane[0]}
                          : {16'h0000, rd_lane[1] | rd_lane[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dout_q <= '0;
    else if (latch) dout_q <= cmd_rd ? dout_d : '0;
  end

  assign data_o    = dout_q;
  assign data_oe_o = (state == ST_WAIT) && cmd_rd;
  assign rdy_no    = !hold;
endmodule

// File: rtl/host_async_chk.sv
module host_async_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sel_s,
  input logic        rdy_no,
  input logic        data_oe_o,
  input logic [31:0] data_o,
  input logic        cmd_rd,
  input logic        cmd_m32,
  input logic [1:0]  cmd_lane,
  input logic [1:0]  mem_we,
  input logic [1:0]  reg_we
);
  assert_wr_mask_hi_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we[1] && cmd_m32) |-> cmd_lane[1]);

  assert_wr_mask_lo_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we[0] && cmd_m32) |-> cmd_lane[0]);

  assert_rd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && cmd_m32 && !cmd_lane[1]) |-> (data_o[31:16] == 16'h0000));

  assert_reg_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we != 2'b00) |-> (cmd_lane == 2'b11));

  assert_ack_when_sel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_no) |-> !sel_s);

  assert_ready_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_no && !sel_s) |=> !rdy_no);

  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_no) |-> $past(sel_s));

  assert_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && !cmd_m32) |-> (data_o[31:16] == 16'h0000));

  assert_oe_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!rdy_no && cmd_rd));
endmodule

bind host_async_slave host_async_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_s     (sel_s),
  .rdy_no    (rdy_no),
  .data_oe_o (data_oe_o),
  .data_o    (data_o),
  .cmd_rd    (cmd_rd),
  .cmd_m32   (cmd_m32),
  .cmd_lane  (cmd_lane),
  .mem_we    (mem_we),
  .reg_we    (reg_we)
);

// File: tb/host_async_slave_tb.sv
`timescale 1ns/1ps
module host_async_slave_tb;
  localparam int MEM_AW = 6;
  localparam int REG_AW = 2;
  localparam int ADDR_W = MEM_AW + 2;
  localparam int NWORD  = 2 ** (MEM_AW + 1);
  localparam int NROW   = 2 ** MEM_AW;
  localparam int NRROW  = 2 ** REG_AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sel_ni = 1'b1;
  logic rd_wr_i = 1'b0;
  logic mode32_i = 1'b1;
  logic [1:0] lane_en_i = 2'b11;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0] data_i = '0;
  logic [31:0] data_o;
  logic data_oe_o, rdy_no;

  always #5 clk = ~clk;

  host_async_slave #(.MEM_AW(MEM_AW), .REG_AW(REG_AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_ni(sel_ni), .rd_wr_i(rd_wr_i),
    .mode32_i(mode32_i), .lane_en_i(lane_en_i), .addr_i(addr_i),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o), .rdy_no(rdy_no)
  );

  int checks = 0;
  int fails  = 0;
  logic [15:0] mem_m [NWORD];
  logic [15:0] reg_m [2*NRROW];

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 40503 + 23068);
  endfunction

  function automatic logic [ADDR_W-1:0] mk(input logic r, input int row, input logic half);
    return {r, 6'(row), half};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic rd, input logic m32, input logic [1:0] ln,
                     input logic [ADDR_W-1:0] ad, input logic [31:0] wd,
                     output logic [31:0] q);
    int n;
    @(negedge clk);
    rd_wr_i = rd; mode32_i = m32; lane_en_i = ln; addr_i = ad; data_i = wd;
    sel_ni = 1'b0;
    n = 0;
    while (n < 40) begin
      @(posedge clk); #1; n++;
      if (!rdy_no) break;
    end
    chk(n == 5, "R6 ready latency", 32'(n), 32'd5);
    q = data_o;
    chk(data_oe_o == rd, "R9 output enable during ack", 32'(data_oe_o), 32'(rd));
    repeat (3) @(posedge clk);
    #1;
    chk(!rdy_no, "R7 ready held while selected", 32'(rdy_no), 32'd0);
    @(negedge clk);
    sel_ni = 1'b1;
    n = 0;
    while (n < 40) begin
      @(posedge clk); #1; n++;
      if (rdy_no) break;
    end
    chk(n == 3, "R7 release latency", 32'(n), 32'd3);
    chk(!data_oe_o, "R9 output enable off after release", 32'(data_oe_o), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] q, exp;
    repeat (3) @(posedge clk);
    #1;
    chk(rdy_no == 1'b1, "R9 reset ready", 32'(rdy_no), 32'd1);
    chk(data_oe_o == 1'b0, "R9 reset oe", 32'(data_oe_o), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk);

    // R1: fill and read back every row in 32-bit mode
    for (int r = 0; r < NROW; r++) begin
      acc(1'b0, 1'b1, 2'b11, mk(1'b0, r, 1'b1), {pat(2*r+1), pat(2*r)}, q);
      mem_m[2*r] = pat(2*r); mem_m[2*r+1] = pat(2*r+1);
    end
    for (int r = 0; r < NROW; r++) begin
      acc(1'b1, 1'b1, 2'b11, mk(1'b0, r, 1'b0), 32'hffff_ffff, q);
      exp = {mem_m[2*r+1], mem_m[2*r]};
      chk(q == exp, "R1 32-bit row mapping", q, exp);
    end

    // R2: masked writes under every lane pattern
    for (int r = 0; r < 8; r++) begin
      for (int l = 0; l < 4; l++) begin
        acc(1'b0, 1'b1, 2'(l), mk(1'b0, r, 1'b0), {pat(r+100+l), pat(r+200+l)}, q);
        if (l[1]) mem_m[2*r+1] = pat(r+100+l);
        if (l[0]) mem_m[2*r]   = pat(r+200+l);
        acc(1'b1, 1'b1, 2'b11, mk(1'b0, r, 1'b0), 32'h0, q);
        exp = {mem_m[2*r+1], mem_m[2*r]};
        chk(q == exp, "R2 write lane mask", q, exp);
      end
    end

    // R3: masked reads under every lane pattern
    for (int r = 0; r < 16; r++) begin
      for (int l = 0; l < 4; l++) begin
        acc(1'b1, 1'b1, 2'(l), mk(1'b0, r, 1'b0), 32'h0, q);
        exp = {(l[1] ? mem_m[2*r+1] : 16'h0), (l[0] ? mem_m[2*r] : 16'h0)};
        chk(q == exp, "R3 read lane zero", q, exp);
      end
    end

    // R4 / R8: 16-bit mode over every word, lanes off, junk on upper data
    for (int w = 0; w < NWORD; w++) begin
      acc(1'b0, 1'b0, 2'b00, {1'b0, 7'(w)}, {16'hdead, pat(w+500)}, q);
      mem_m[w] = pat(w+500);
    end
    for (int w = 0; w < NWORD; w++) begin
      acc(1'b1, 1'b0, 2'(w % 4), {1'b0, 7'(w)}, 32'h0, q);
      chk(q[15:0] == mem_m[w], "R4 16-bit word", {16'h0, q[15:0]}, {16'h0, mem_m[w]});
      chk(q[31:16] == 16'h0, "R8 16-bit upper zero", {16'h0, q[31:16]}, 32'h0);
    end
    // R1: 16-bit writes seen in 32-bit halves
    for (int r = 0; r < NROW; r++) begin
      acc(1'b1, 1'b1, 2'b11, mk(1'b0, r, 1'b0), 32'h0, q);
      exp = {mem_m[2*r+1], mem_m[2*r]};
      chk(q == exp, "R1 even word low half", q, exp);
    end

    // R5: register file
    for (int r = 0; r < NRROW; r++) begin
      acc(1'b0, 1'b1, 2'b11, mk(1'b1, r, 1'b0), {pat(r+900), pat(r+800)}, q);
      reg_m[2*r] = pat(r+800); reg_m[2*r+1] = pat(r+900);
    end
    for (int r = 0; r < NRROW; r++) begin
      for (int l = 0; l < 3; l++) begin
        acc(1'b0, 1'b1, 2'(l), mk(1'b1, r, 1'b0), 32'hbad0_bad0, q);
        acc(1'b1, 1'b1, 2'(l), mk(1'b1, r, 1'b0), 32'h0, q);
        chk(q == 32'h0, "R5 partial-lane register read zero", q, 32'h0);
      end
      acc(1'b1, 1'b1, 2'b11, mk(1'b1, r, 1'b0), 32'h0, q);
      exp = {reg_m[2*r+1], reg_m[2*r]};
      chk(q == exp, "R5 register unchanged by partial lanes", q, exp);
    end
    // R5: 16-bit register write proceeds regardless of lanes
    acc(1'b0, 1'b0, 2'b00, mk(1'b1, 2, 1'b1), 32'hffff_7e57, q);
    reg_m[5] = 16'h7e57;
    acc(1'b1, 1'b1, 2'b11, mk(1'b1, 2, 1'b0), 32'h0, q);
    exp = {reg_m[5], reg_m[4]};
    chk(q == exp, "R5 16-bit register write", q, exp);
    // memory untouched by register traffic
    acc(1'b1, 1'b1, 2'b11, mk(1'b0, 2, 1'b0), 32'h0, q);
    exp = {mem_m[5], mem_m[4]};
    chk(q == exp, "R5 memory isolated from registers", q, exp);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule